// File: doc/BRIEF.md
# Binary Image Majority Downscaler

This block shrinks a one-bit-per-pixel image held in an external source memory. The image is cut into square tiles of K by K pixels. Each tile becomes a single output pixel that takes the value held by most of the tile's pixels. The result goes to an external destination memory as an image K times narrower and K times shorter. A single `start` pulse runs one complete pass. The block fetches every source pixel once, in tile order, over consecutive cycles. Each tile's result is written while the reads of the next tile are already under way. A one-cycle `done` pulse closes the pass.

The tile size comes from a two-bit `scale_sel` code and is sampled when a pass starts. The image dimensions are parameters. Both must be multiples of 8 so that every supported tile size divides the image exactly. The source memory is addressed linearly as `row * IMG_W + col` and returns data one cycle after the address. The destination memory takes one write per tile, addressed by tile index.

Top module: `bin_tile_downscaler`

## Requirements
- R1: A pass over an IMG_W x IMG_H image with tile size K makes exactly (IMG_W/K)*(IMG_H/K) destination writes, one per tile, all to addresses below that count.
- R2: A tile's output bit is 1 when the tile holds more 1-pixels than 0-pixels, and 0 when it holds more 0-pixels than 1-pixels.
- R3: When a tile holds exactly as many 1-pixels as 0-pixels, its output bit is 0.
- R4: `scale_sel` selects the tile size: 0 gives K=2, 1 gives K=4, 2 gives K=8, and the spare code 3 also gives K=8.
- R5: The first source read address appears on `src_rd_addr`, with `src_rd_en` high, in the cycle after `start` is sampled. Reads then continue on IMG_W*IMG_H consecutive cycles with no gap. Tiles are visited in row-major tile order, and the K*K pixels inside a tile are read in row-major order. Each read address is `row * IMG_W + col`.
- R6: A tile's destination write appears two cycles after the read of its last pixel is presented. The write address is the tile's row-major tile index, starting at 0 and rising by one per tile.
- R7: `done` is high for exactly one cycle, the cycle after the last destination write, and is low at every other time.
- R8: A `start` pulse during a pass is ignored, and a change of `scale_sel` during a pass does not alter that pass.
- R9: While reset is applied and after it, `src_rd_en`, `dst_wr_en` and `done` are low until a pass starts.
- R10: The pixel counts restart at every tile, so a tile's result depends only on its own pixels, whatever the preceding tile held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a pass when the block is idle |
| scale_sel | input | 2 | Tile size code, sampled at start |
| done | output | 1 | One-cycle pulse at the end of a pass |
| src_rd_en | output | 1 | Source memory read strobe |
| src_rd_addr | output | $clog2(IMG_W*IMG_H) | Source pixel address |
| src_rd_data | input | 1 | Source pixel, valid one cycle after the read |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | $clog2((IMG_W/2)*(IMG_H/2)) | Destination tile index |
| dst_wr_data | output | 1 | Majority bit for the tile |

## Verification
The bench builds the block for a 24 x 16 image. The width is then not a power of two and the tile grid is not square. This exercises the constant-width row multiply and the separate horizontal and vertical tile wrap for every tile size. At this size, all four `scale_sel` codes produce grids of 96, 24 and 6 tiles. The tile patterns are built to give majority, tie and minority results in adjacent tiles, so any carry-over of counts between tiles shows up. One pass changes `scale_sel` and pulses `start` while the pass is running.

// File: rtl/dscl_pkg.sv
package dscl_pkg;

  localparam int MAX_K = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_DRAIN
  } phase_e;

  // log2 of the tile edge for each selection code (R4): 0->2, 1->4, 2/3->8
  function automatic logic [1:0] sel_to_lg(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/dscl_addr_gen.sv
module dscl_addr_gen #(
  parameter  int IMG_W = 16,
  parameter  int IMG_H = 16,
  localparam int PIX   = IMG_W * IMG_H,
  localparam int AW    = $clog2(PIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic [1:0]    lg,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_tile_last,
  output logic          rd_img_last,
  output logic          img_last_now
);

  localparam int TXW = $clog2(IMG_W);
  localparam int TYW = $clog2(IMG_H);

  logic [2:0]     px_q, py_q;
  logic [TXW-1:0] tx_q;
  logic [TYW-1:0] ty_q;

  logic [2:0]     kmask;
  logic [TXW-1:0] tx_max;
  logic [TYW-1:0] ty_max;
  logic           px_end, py_end, tx_end, ty_end, tile_end;
  logic [AW-1:0]  row, col, addr_nx;

  always_comb begin
    kmask    = 3'((4'd1 << lg) - 4'd1);
    tx_max   = TXW'((IMG_W >> lg) - 1);
    ty_max   = TYW'((IMG_H >> lg) - 1);
    px_end   = (px_q == kmask);
    py_end   = (py_q == kmask);
    tx_end   = (tx_q == tx_max);
    ty_end   = (ty_q == ty_max);
    tile_end = px_end & py_end;
    row      = (AW'(ty_q) << lg) | AW'(py_q);
    col      = (AW'(tx_q) << lg) | AW'(px_q);
    addr_nx  = row * AW'(IMG_W) + col;
  end

  assign img_last_now = run & tile_end & tx_end & ty_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      px_q         <= '0;
      py_q         <= '0;
      tx_q         <= '0;
      ty_q         <= '0;
      rd_en        <= 1'b0;
      rd_addr      <= '0;
      rd_tile_last <= 1'b0;
      rd_img_last  <= 1'b0;
    end else begin
      rd_en <= run;
      if (run) begin
        rd_addr      <= addr_nx;
        rd_tile_last <= tile_end;
        rd_img_last  <= tile_end & tx_end & ty_end;
        if (!px_end) begin
          px_q <= px_q + 3'd1;
        end else begin
          px_q <= '0;
          if (!py_end) begin
            py_q <= py_q + 3'd1;
          end else begin
            py_q <= '0;
            if (!tx_end) begin
              tx_q <= tx_q + TXW'(1);
            end else begin
              tx_q <= '0;
              ty_q <= ty_end ? '0 : ty_q + TYW'(1);
            end
          end
        end
      end
      if (clear) begin
        px_q <= '0;
        py_q <= '0;
        tx_q <= '0;
        ty_q <= '0;
      end
    end
  end

endmodule

// File: rtl/dscl_vote.sv
module dscl_vote
  import dscl_pkg::*;
#(
  localparam int CNT_W = $clog2(MAX_K * MAX_K + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic in_vld,
  input  logic in_bit,
  input  logic in_last,
  output logic tile_done,
  output logic maj_bit
);

  logic [CNT_W-1:0] ones_q, zeros_q, ones_nx, zeros_nx;
  logic             is_zero;

  always_comb begin
    is_zero   = in_bit ^ 1'b1;
    ones_nx   = ones_q  + CNT_W'(in_vld & ~is_zero);
    zeros_nx  = zeros_q + CNT_W'(in_vld &  is_zero);
    tile_done = in_vld & in_last;
    maj_bit   = (ones_nx > zeros_nx);   // tie resolves to 0
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ones_q  <= '0;
      zeros_q <= '0;
    end else if (in_vld) begin
      if (in_last) begin
        ones_q  <= '0;
        zeros_q <= '0;
      end else begin
        ones_q  <= ones_nx;
        zeros_q <= zeros_nx;
      end
    end
  end

endmodule

// File: rtl/dscl_wb.sv
module dscl_wb #(
  parameter  int IMG_W = 16,
  parameter  int IMG_H = 16,
  localparam int DAW   = $clog2((IMG_W / 2) * (IMG_H / 2))
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           res_vld,
  input  logic           res_bit,
  input  logic           res_last,
  output logic           wr_en,
  output logic [DAW-1:0] wr_addr,
  output logic           wr_data,
  output logic           done
);

  logic [DAW-1:0] tile_idx_q;
  logic           wr_last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tile_idx_q <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= 1'b0;
      wr_last_q  <= 1'b0;
      done       <= 1'b0;
    end else begin
      wr_en     <= res_vld;
      wr_last_q <= res_vld & res_last;
      done      <= wr_en & wr_last_q;
      if (res_vld) begin
        wr_addr    <= tile_idx_q;
        wr_data    <= res_bit;
        tile_idx_q <= tile_idx_q + DAW'(1);
      end
      if (clear) tile_idx_q <= '0;
    end
  end

endmodule

// File: rtl/bin_tile_downscaler.sv
module bin_tile_downscaler
  import dscl_pkg::*;
#(
  parameter  int IMG_W = 16,
  parameter  int IMG_H = 16,
  localparam int AW    = $clog2(IMG_W * IMG_H),
  localparam int DAW   = $clog2((IMG_W / 2) * (IMG_H / 2))
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     scale_sel,
  output logic           done,
  output logic           src_rd_en,
  output logic [AW-1:0]  src_rd_addr,
  input  logic           src_rd_data,
  output logic           dst_wr_en,
  output logic [DAW-1:0] dst_wr_addr,
  output logic           dst_wr_data
);

  phase_e     ph_q;
  logic [1:0] lg_q;
  logic       accept, run, img_last_now;
  logic       rd_tile_last, rd_img_last;
  logic       d_vld, d_last, d_img;
  logic       tile_done, maj_bit;

  assign accept = (ph_q == PH_IDLE) & start;
  assign run    = (ph_q == PH_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
      lg_q <= 2'd1;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) begin
          ph_q <= PH_READ;
          lg_q <= sel_to_lg(scale_sel);
        end
        PH_READ:  if (img_last_now) ph_q <= PH_DRAIN;
        PH_DRAIN: if (done) ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

  dscl_addr_gen #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .clear       (accept),
    .run         (run),
    .lg          (lg_q),
    .rd_en       (src_rd_en),
    .rd_addr     (src_rd_addr),
    .rd_tile_last(rd_tile_last),
    .rd_img_last (rd_img_last),
    .img_last_now(img_last_now)
  );

  // align tile markers with the one-cycle read latency of the source memory
  always_ff @(posedge clk) begin
    if (rst) begin
      d_vld  <= 1'b0;
      d_last <= 1'b0;
      d_img  <= 1'b0;
    end else begin
      d_vld  <= src_rd_en;
      d_last <= rd_tile_last;
      d_img  <= rd_img_last;
    end
  end

  dscl_vote u_vote (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .in_vld   (d_vld),
    .in_bit   (src_rd_data),
    .in_last  (d_last),
    .tile_done(tile_done),
    .maj_bit  (maj_bit)
  );

  dscl_wb #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_wb (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .res_vld (tile_done),
    .res_bit (maj_bit),
    .res_last(d_img),
    .wr_en   (dst_wr_en),
    .wr_addr (dst_wr_addr),
    .wr_data (dst_wr_data),
    .done    (done)
  );

endmodule

// File: rtl/dscl_chk.sv
module dscl_chk #(
  parameter  int IMG_W = 16,
  parameter  int IMG_H = 16,
  localparam int PIX   = IMG_W * IMG_H,
  localparam int TMAX  = (IMG_W / 2) * (IMG_H / 2),
  localparam int AW    = $clog2(PIX),
  localparam int DAW   = $clog2(TMAX)
) (
  input logic           clk,
  input logic           rst,
  input logic           done,
  input logic           src_rd_en,
  input logic [AW-1:0]  src_rd_addr,
  input logic           dst_wr_en,
  input logic [DAW-1:0] dst_wr_addr
);

  logic           seen_q;
  logic [DAW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (dst_wr_en) begin
      seen_q <= 1'b1;
      last_q <= dst_wr_addr;
    end
  end

  a_r5_read_in_range: assert property (@(posedge clk) disable iff (rst)
    src_rd_en |-> int'(src_rd_addr) < PIX);

  a_r1_write_in_range: assert property (@(posedge clk) disable iff (rst)
    dst_wr_en |-> int'(dst_wr_addr) < TMAX);

  a_r6_first_write_zero: assert property (@(posedge clk) disable iff (rst)
    (dst_wr_en && !seen_q) |-> dst_wr_addr == '0);

  a_r6_write_addr_step: assert property (@(posedge clk) disable iff (rst)
    (dst_wr_en && seen_q) |-> dst_wr_addr == last_q + DAW'(1));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(dst_wr_en));

  a_r7_done_no_read: assert property (@(posedge clk) disable iff (rst)
    done |-> !src_rd_en);

endmodule

bind bin_tile_downscaler dscl_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .done       (done),
  .src_rd_en  (src_rd_en),
  .src_rd_addr(src_rd_addr),
  .dst_wr_en  (dst_wr_en),
  .dst_wr_addr(dst_wr_addr)
);

// File: tb/test_bin_tile_downscaler.sv
module test_bin_tile_downscaler;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 24;
  localparam int H    = 16;
  localparam int P    = W * H;
  localparam int TMAX = (W / 2) * (H / 2);
  localparam int AW   = $clog2(P);
  localparam int DAW  = $clog2(TMAX);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [1:0]     scale_sel = 2'd0;
  logic           done, src_rd_en, src_rd_data, dst_wr_en, dst_wr_data;
  logic [AW-1:0]  src_rd_addr;
  logic [DAW-1:0] dst_wr_addr;

  int n_checks = 0;
  int n_fail   = 0;

  bit src   [P];
  bit dst   [TMAX];
  bit maj   [TMAX];
  bit tie   [TMAX];
  int order [P];

  always #(CLK_PERIOD / 2) clk = ~clk;

  bin_tile_downscaler #(.IMG_W(W), .IMG_H(H)) i_bin_tile_downscaler (
    .clk(clk), .rst(rst), .start(start), .scale_sel(scale_sel), .done(done),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data)
  );

  // source memory: synchronous read, one cycle latency
  logic rd_q = 1'b0;
  always @(posedge clk) if (src_rd_en) rd_q <= src[src_rd_addr];
  assign src_rd_data = rd_q;

  always @(posedge clk) if (dst_wr_en) dst[dst_wr_addr] <= dst_wr_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int k_of(input int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 4 : 8;   // R4
  endfunction

  // kind: 0 zeros, 1 ones, 2 checkerboard, 3 random, 4 crafted per-tile counts
  task automatic fill(input int kind, input int k);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        int t, j, want;
        t    = (r / k) * (W / k) + (c / k);
        j    = (r % k) * k + (c % k);
        want = k * k / 2 + ((t % 3 == 0) ? 1 : (t % 3 == 1) ? 0 : -1);
        case (kind)
          0:       src[r*W+c] = 1'b0;
          1:       src[r*W+c] = 1'b1;
          2:       src[r*W+c] = bit'((r + c) % 2);
          3:       src[r*W+c] = bit'($urandom % 2);
          default: src[r*W+c] = (j < want);
        endcase
      end
    end
  endtask

  task automatic build_ref(input int k);
    int i;
    i = 0;
    for (int ty = 0; ty < H / k; ty++)
      for (int tx = 0; tx < W / k; tx++) begin
        int ones;
        ones = 0;
        for (int py = 0; py < k; py++)
          for (int px = 0; px < k; px++) begin
            order[i] = (ty * k + py) * W + tx * k + px;
            ones += int'(src[order[i]]);
            i++;
          end
        maj[ty*(W/k)+tx] = (2 * ones > k * k);
        tie[ty*(W/k)+tx] = (2 * ones == k * k);
      end
  endtask

  task automatic run_pass(input int sel, input int kind, input bit disturb, input string tag);
    int k, kk, t, wr_cnt;
    string rtag, wtag;
    k  = k_of(sel);
    kk = k * k;
    t  = (W / k) * (H / k);
    fill(kind, k);
    build_ref(k);
    for (int i = 0; i < TMAX; i++) dst[i] = 1'b0;
    rtag = disturb ? "R8 read" : "R5 read";
    wtag = disturb ? "R8 write" : "R6 write";
    wr_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    scale_sel = 2'(sel);
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= P + 5; n++) begin
      int i;
      bit e_rd, e_wr;
      @(negedge clk);
      e_rd = (n >= 1) && (n <= P);
      chk(src_rd_en == e_rd, rtag, int'(src_rd_en), int'(e_rd));
      if (e_rd && src_rd_en)
        chk(int'(src_rd_addr) == order[n-1], rtag, int'(src_rd_addr), order[n-1]);
      i    = n - 3;
      e_wr = (i >= 0) && (i < P) && ((i + 1) % kk == 0);
      chk(dst_wr_en == e_wr, wtag, int'(dst_wr_en), int'(e_wr));
      if (dst_wr_en) wr_cnt++;
      if (e_wr && dst_wr_en) begin
        chk(int'(dst_wr_addr) == (i + 1) / kk - 1, wtag, int'(dst_wr_addr), (i + 1) / kk - 1);
        chk(dst_wr_data == maj[(i+1)/kk-1], tie[(i+1)/kk-1] ? "R3" : tag,
            int'(dst_wr_data), int'(maj[(i+1)/kk-1]));
      end
      chk(done == (n == P + 3), "R7 done", int'(done), int'(n == P + 3));
      if (disturb && n == 5) scale_sel = 2'(sel ^ 1);
      if (disturb && n == P / 2) start = 1'b1;
      if (disturb && n == P / 2 + 1) start = 1'b0;
    end
    chk(wr_cnt == t, "R1 write count", wr_cnt, t);
    for (int j = 0; j < t; j++)
      chk(dst[j] == maj[j], tie[j] ? "R3 image" : tag, int'(dst[j]), int'(maj[j]));
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!src_rd_en, "R9 reset rd_en", int'(src_rd_en), 0);
    chk(!dst_wr_en, "R9 reset wr_en", int'(dst_wr_en), 0);
    chk(!done, "R9 reset done", int'(done), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!src_rd_en && !dst_wr_en && !done, "R9 idle after reset",
        int'({src_rd_en, dst_wr_en, done}), 0);
    run_pass(0, 3, 1'b0, "R2");
    run_pass(0, 0, 1'b0, "R2");
    run_pass(1, 1, 1'b0, "R2");
    run_pass(0, 2, 1'b0, "R3");
    run_pass(2, 2, 1'b0, "R3");
    run_pass(0, 4, 1'b0, "R10");
    run_pass(1, 4, 1'b0, "R10");
    run_pass(2, 4, 1'b0, "R10");
    run_pass(3, 3, 1'b0, "R4");
    run_pass(3, 4, 1'b0, "R4");
    run_pass(1, 3, 1'b1, "R8");
    run_pass(2, 4, 1'b1, "R8");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule